// File: doc/BRIEF.md
# TDM Audio Serial Port (Slave)

This block is the digital edge of a multichannel audio converter. An external master supplies a bit clock and a frame sync. The block follows them and carries audio in both directions over one serial line each way. Each frame is 256 bit clocks long and is split into eight slots of 32 clocks. Every slot holds one 24-bit sample, most significant bit first, placed at the start of the slot. The remaining eight clocks of each slot are padding.

On the inbound line, the first six slots hold six playback channels. The block collects them and hands all six words over together, with a single-cycle strobe. On the outbound line, the block sends four local capture channels in the first four slots. It keeps the next two slots silent and puts two auxiliary capture channels in the last two slots. A parallel capture interface supplies all six outbound words. They are frozen at each frame start and acknowledged with a one-cycle pulse. If a sync arrives early, the block realigns to it and flags the event.

Top module: `tdm_audio_port`

## Requirements
- R1: While and after reset, before any frame sync, `sdout`, `play_valid`, `cap_ack` and `sync_err` are 0 and `play_data` is all zeros.
- R2: A frame starts at the `sclk` rising edge where `fs` is seen high after being low. The MSB of slot 1 is sampled at the next rising edge. An `fs` held high for many clocks, such as a full 32-clock slot, starts only one frame.
- R3: Inbound bits 0..23 of slots 1..6 form playback channels 0..5, MSB first. Channel k appears on `play_data[24k+23:24k]`. Bits 24..31 of every slot, and all of slots 7 and 8, are discarded. `play_data` changes only together with `play_valid`.
- R4: `play_valid` is a one-cycle pulse after the rising edge that samples bit 23 of slot 6, which is frame bit 183. All six words update at that moment.
- R5: Outbound slots 1..4 carry `cap_data` words 0..3, and slots 7 and 8 carry words 4 and 5. Each word is sent MSB first in bits 0..23 of its slot. `sdout` changes on falling `sclk` edges, so each bit is stable at the receiver's rising edge.
- R6: `sdout` is 0 throughout slots 5 and 6, and in bits 24..31 of every slot.
- R7: `cap_data` is captured at the frame-start edge, and `cap_ack` pulses high for the following cycle. Changes to `cap_data` after that edge do not affect the frame in progress.
- R8: A frame start that comes at any edge other than exactly 256 clocks after the previous one raises `sync_err` for one cycle and realigns the frame. An aborted frame produces no `play_valid`.
- R9: Back-to-back frames with syncs exactly 256 clocks apart never raise `sync_err`. When no new sync arrives, the slot position wraps and continues without error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Bit clock from the external master |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `sclk` |
| fs | input | 1 | Frame sync, one clock or a word wide |
| sdin | input | 1 | Inbound serial playback data |
| sdout | output | 1 | Outbound serial capture data |
| play_data | output | 144 | Six 24-bit playback words, channel k at bits 24k+23..24k |
| play_valid | output | 1 | One-cycle strobe: new playback set |
| cap_data | input | 144 | Six 24-bit capture words: 0..3 local, 4..5 auxiliary |
| cap_ack | output | 1 | One-cycle pulse: `cap_data` was taken for the new frame |
| sync_err | output | 1 | One-cycle pulse on an early frame sync |

## Verification
The bench builds the block with its default parameters: 32-clock slots, eight slots, 24-bit words, six playback channels, and four local plus two auxiliary capture channels. With these values one frame costs only 256 clocks, so about a dozen frames with both sync widths, early syncs before and after the playback strobe point, a mid-frame capture change and a long sync-free stretch all fit well inside the run. A behavioural model tracks the frame position and compares every outbound bit, strobe and word on every clock.

// File: rtl/tdm_pkg.sv
`timescale 1ns/1ps
package tdm_pkg;
  localparam int unsigned DEF_SLOT_W  = 32;
  localparam int unsigned DEF_N_SLOT  = 8;
  localparam int unsigned DEF_SAMP_W  = 24;
  localparam int unsigned DEF_N_PLAY  = 6;
  localparam int unsigned DEF_N_LOCAL = 4;
  localparam int unsigned DEF_N_AUX   = 2;

  // What an outbound slot carries
  typedef enum logic [1:0] {ROLE_LOCAL, ROLE_EMPTY, ROLE_AUX} slot_role_e;
endpackage

// File: rtl/tdm_frame_ctrl.sv
`timescale 1ns/1ps
module tdm_frame_ctrl #(
  parameter int unsigned FRAME_LEN = 256,
  parameter int unsigned CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs,
  output logic             active,
  output logic [CNT_W-1:0] bit_idx,
  output logic             start,
  output logic             sync_err
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic             fs_q;
  logic             act_d;
  logic [CNT_W-1:0] idx_d;
  logic             err_d;

  assign start = fs & ~fs_q;

  // bit_idx: frame bit index sampled at the coming rising edge
  always_comb begin
    act_d = active;
    idx_d = bit_idx;
    err_d = 1'b0;
    if (start) begin
      act_d = 1'b1;
      idx_d = '0;
      err_d = active && (bit_idx != LAST);
    end else if (active) begin
      idx_d = (bit_idx == LAST) ? '0 : bit_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q     <= 1'b0;
      active   <= 1'b0;
      bit_idx  <= '0;
      sync_err <= 1'b0;
    end else begin
      fs_q     <= fs;
      active   <= act_d;
      bit_idx  <= idx_d;
      sync_err <= err_d;
    end
  end

  // R8: an error only ever accompanies a freshly restarted frame
  a_r8_err_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> (active && bit_idx == '0));
endmodule

// File: rtl/tdm_rx_deser.sv
`timescale 1ns/1ps
module tdm_rx_deser #(
  parameter int unsigned SLOT_W = 32,
  parameter int unsigned SAMP_W = 24,
  parameter int unsigned N_PLAY = 6,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned BIT_W  = $clog2(SLOT_W)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     active,
  input  logic                     start,
  input  logic [CNT_W-1:0]         bit_idx,
  input  logic                     sdin,
  output logic [N_PLAY*SAMP_W-1:0] play_data,
  output logic                     play_valid
);
  localparam int unsigned SLOT_IW = CNT_W - BIT_W;

  logic [SLOT_IW-1:0] slot;
  logic [BIT_W-1:0]   bpos;
  logic               in_word, word_done, frame_done;
  logic [SAMP_W-2:0]  sh, sh_d;
  logic [SAMP_W-1:0]  new_word;
  logic [SAMP_W-1:0]  stage  [N_PLAY-1];
  logic [SAMP_W-1:0]  play_q [N_PLAY];

  assign slot       = bit_idx[CNT_W-1:BIT_W];
  assign bpos       = bit_idx[BIT_W-1:0];
  assign in_word    = active && !start && (slot < SLOT_IW'(N_PLAY)) && (bpos < BIT_W'(SAMP_W));
  assign word_done  = in_word && (bpos == BIT_W'(SAMP_W - 1));
  assign frame_done = word_done && (slot == SLOT_IW'(N_PLAY - 1));
  assign new_word   = {sh, sdin};
  assign sh_d       = in_word ? {sh[SAMP_W-3:0], sdin} : sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh         <= '0;
      play_valid <= 1'b0;
    end else begin
      sh         <= sh_d;
      play_valid <= frame_done;
    end
  end

  for (genvar ch = 0; ch < N_PLAY; ch++) begin : g_chan
    if (ch < N_PLAY - 1) begin : g_staged
      logic stage_en;
      assign stage_en = word_done && (slot == SLOT_IW'(ch));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          stage[ch] <= '0;
        else if (stage_en)   stage[ch] <= new_word;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          play_q[ch] <= '0;
        else if (frame_done) play_q[ch] <= stage[ch];
      end
    end else begin : g_last
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          play_q[ch] <= '0;
        else if (frame_done) play_q[ch] <= new_word;
      end
    end
    assign play_data[ch*SAMP_W +: SAMP_W] = play_q[ch];
  end

  // R4: strobe lasts one cycle and sits right after the last playback bit
  a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    play_valid |=> !play_valid);
  a_r4_valid_position: assert property (@(posedge clk) disable iff (!rst_n)
    play_valid |-> (bit_idx == CNT_W'((N_PLAY - 1) * SLOT_W + SAMP_W)));
  // R3: words move only together with the strobe
  a_r3_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !play_valid |-> $stable(play_data));
endmodule

// File: rtl/tdm_tx_ser.sv
`timescale 1ns/1ps
module tdm_tx_ser
  import tdm_pkg::*;
#(
  parameter int unsigned N_SLOT  = 8,
  parameter int unsigned SAMP_W  = 24,
  parameter int unsigned N_LOCAL = 4,
  parameter int unsigned N_AUX   = 2,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned BIT_W   = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              active,
  input  logic                              start,
  input  logic [CNT_W-1:0]                  bit_idx,
  input  logic [(N_LOCAL+N_AUX)*SAMP_W-1:0] cap_data,
  output logic                              sdout,
  output logic                              cap_ack
);
  localparam int unsigned N_CAP    = N_LOCAL + N_AUX;
  localparam int unsigned AUX_BASE = N_SLOT - N_AUX;
  localparam int unsigned SLOT_IW  = CNT_W - BIT_W;

  function automatic slot_role_e role_of(input int unsigned s);
    if (s < N_LOCAL)        return ROLE_LOCAL;
    else if (s >= AUX_BASE) return ROLE_AUX;
    else                    return ROLE_EMPTY;
  endfunction

  logic [N_CAP*SAMP_W-1:0] cap_q;
  logic [SLOT_IW-1:0]      slot;
  logic [BIT_W-1:0]        bpos;
  slot_role_e              role;
  int unsigned             word_sel, bit_sel;
  logic                    tx_bit;

  assign slot = bit_idx[CNT_W-1:BIT_W];
  assign bpos = bit_idx[BIT_W-1:0];

  always_comb begin
    role     = role_of(32'(slot));
    word_sel = (role == ROLE_AUX) ? N_LOCAL + 32'(slot) - AUX_BASE : 32'(slot);
    bit_sel  = word_sel * SAMP_W + (SAMP_W - 1) - 32'(bpos);
    tx_bit   = 1'b0;
    if (active && role != ROLE_EMPTY && bpos < BIT_W'(SAMP_W))
      tx_bit = cap_q[bit_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      cap_ack <= 1'b0;
    end else begin
      if (start) cap_q <= cap_data;
      cap_ack <= start;
    end
  end

  // Launch on the falling edge so the bit is settled at the sampling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sdout <= 1'b0;
    else        sdout <= tx_bit;
  end

  // R6: silent slots and padding bits are zero on the line
  a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (role == ROLE_EMPTY || bpos >= BIT_W'(SAMP_W))) |-> !sdout);
  // R7: outbound words stay frozen between frame starts
  a_r7_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(cap_q));
endmodule

// File: rtl/tdm_audio_port.sv
`timescale 1ns/1ps
module tdm_audio_port
  import tdm_pkg::*;
#(
  parameter int unsigned SLOT_W  = DEF_SLOT_W,
  parameter int unsigned N_SLOT  = DEF_N_SLOT,
  parameter int unsigned SAMP_W  = DEF_SAMP_W,
  parameter int unsigned N_PLAY  = DEF_N_PLAY,
  parameter int unsigned N_LOCAL = DEF_N_LOCAL,
  parameter int unsigned N_AUX   = DEF_N_AUX
) (
  input  logic                              sclk,
  input  logic                              rst_n,
  input  logic                              fs,
  input  logic                              sdin,
  output logic                              sdout,
  output logic [N_PLAY*SAMP_W-1:0]          play_data,
  output logic                              play_valid,
  input  logic [(N_LOCAL+N_AUX)*SAMP_W-1:0] cap_data,
  output logic                              cap_ack,
  output logic                              sync_err
);
  localparam int unsigned FRAME_LEN = N_SLOT * SLOT_W;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN);
  localparam int unsigned BIT_W     = $clog2(SLOT_W);

  logic             active, start;
  logic [CNT_W-1:0] bit_idx;

  tdm_frame_ctrl #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_ctrl (
    .clk(sclk), .rst_n(rst_n), .fs(fs), .active(active),
    .bit_idx(bit_idx), .start(start), .sync_err(sync_err)
  );

  tdm_rx_deser #(.SLOT_W(SLOT_W), .SAMP_W(SAMP_W), .N_PLAY(N_PLAY),
                 .CNT_W(CNT_W), .BIT_W(BIT_W)) u_rx (
    .clk(sclk), .rst_n(rst_n), .active(active), .start(start),
    .bit_idx(bit_idx), .sdin(sdin), .play_data(play_data), .play_valid(play_valid)
  );

  tdm_tx_ser #(.N_SLOT(N_SLOT), .SAMP_W(SAMP_W), .N_LOCAL(N_LOCAL),
               .N_AUX(N_AUX), .CNT_W(CNT_W), .BIT_W(BIT_W)) u_tx (
    .clk(sclk), .rst_n(rst_n), .active(active), .start(start),
    .bit_idx(bit_idx), .cap_data(cap_data), .sdout(sdout), .cap_ack(cap_ack)
  );
endmodule

// File: tb/tdm_audio_port_test.sv
`timescale 1ns/1ps
module tdm_audio_port_test;
  localparam int SW = 24;
  localparam int NP = 6;
  localparam int NC = 6;

  logic sclk = 1'b0, rst_n = 1'b0, fs = 1'b0, sdin = 1'b0;
  logic [NC*SW-1:0] cap_data = '0;
  logic [NP*SW-1:0] play_data;
  logic sdout, play_valid, cap_ack, sync_err;

  always #10 sclk = ~sclk;  // 50 MHz

  tdm_audio_port uut (
    .sclk(sclk), .rst_n(rst_n), .fs(fs), .sdin(sdin), .sdout(sdout),
    .play_data(play_data), .play_valid(play_valid), .cap_data(cap_data),
    .cap_ack(cap_ack), .sync_err(sync_err)
  );

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // Behavioural reference state
  bit m_active = 0, m_fsq = 0;
  int m_cnt = 0;
  logic [SW-1:0] m_rx[NP], m_play[NP], m_cap[NC];
  bit e_valid = 0, e_err = 0, e_ack = 0;
  int nvalid = 0, nerr = 0;

  task automatic chk(string req, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s act=%0b exp=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic exp_tx();
    int slot, b;
    if (!m_active) return 1'b0;
    slot = m_cnt / 32; b = m_cnt % 32;
    if (b >= SW) return 1'b0;
    if (slot < 4) return m_cap[slot][SW-1-b];
    if (slot >= 6) return m_cap[4 + slot - 6][SW-1-b];
    return 1'b0;
  endfunction

  function automatic logic [NP*SW-1:0] exp_play_flat();
    logic [NP*SW-1:0] v;
    for (int k = 0; k < NP; k++) v[k*SW +: SW] = m_play[k];
    return v;
  endfunction

  task automatic step(bit fsv, bit dv);
    string rq;
    int slot, b;
    @(negedge sclk); #2;
    slot = m_cnt / 32; b = m_cnt % 32;
    if (!m_active) rq = "R1";
    else if (slot == 4 || slot == 5 || b >= SW) rq = "R6";
    else rq = "R5";
    chk(rq, "sdout", sdout, exp_tx());
    fs = fsv; sdin = dv;
    @(posedge sclk); #2;
    e_valid = 0; e_err = 0; e_ack = 0;
    if (fsv && !m_fsq) begin
      e_err = m_active && (m_cnt != 255);
      m_active = 1; m_cnt = 0; e_ack = 1;
      for (int k = 0; k < NC; k++) m_cap[k] = cap_data[k*SW +: SW];
    end else if (m_active) begin
      slot = m_cnt / 32; b = m_cnt % 32;
      if (slot < NP && b < SW) m_rx[slot][SW-1-b] = dv;
      if (slot == NP-1 && b == SW-1) begin
        for (int k = 0; k < NP; k++) m_play[k] = m_rx[k];
        e_valid = 1;
      end
      m_cnt = (m_cnt + 1) % 256;
    end
    m_fsq = fsv;
    if (e_valid) nvalid++;
    if (e_err) nerr++;
    chk("R4", "play_valid", play_valid, e_valid);
    chk("R8", "sync_err", sync_err, e_err);
    chk("R7", "cap_ack", cap_ack, e_ack);
    vectors++;
    if (play_data !== exp_play_flat()) begin
      miscompares++;
      $display("FAIL R3 play_data act=%h exp=%h", play_data, exp_play_flat());
    end
  endtask

  task automatic new_cap();
    for (int k = 0; k < NC; k++) cap_data[k*SW +: SW] = SW'($urandom);
  endtask

  task automatic frame(int fs_w, int len);
    new_cap();
    for (int j = 0; j < len; j++) begin
      if (j == 100) new_cap();  // R7: mid-frame change must not leak out
      step(j < fs_w, 1'($urandom));
    end
  endtask

  task automatic count_chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    for (int k = 0; k < NP; k++) begin m_rx[k] = '0; m_play[k] = '0; end
    for (int k = 0; k < NC; k++) m_cap[k] = '0;
    repeat (3) @(posedge sclk);
    #2;
    // R1: reset state
    chk("R1", "sdout", sdout, 1'b0);
    chk("R1", "play_valid", play_valid, 1'b0);
    chk("R1", "sync_err", sync_err, 1'b0);
    chk("R1", "cap_ack", cap_ack, 1'b0);
    count_chk("R1", "play_data nonzero", int'(play_data != '0), 0);
    @(negedge sclk); rst_n = 1'b1;
    repeat (10) step(1'b0, 1'($urandom));
    // R9: on-time single-clock syncs
    repeat (3) frame(1, 256);
    count_chk("R9", "errors on-time", nerr, 0);
    // R2: word-wide sync starts only one frame each
    repeat (2) frame(32, 256);
    count_chk("R2", "valids after wide syncs", nvalid, 5);
    count_chk("R2", "errors after wide syncs", nerr, 0);
    // R8: early sync before the strobe point, then after it
    frame(1, 150);
    frame(1, 256);
    frame(1, 200);
    frame(32, 256);
    repeat (2) frame(1, 256);
    count_chk("R8", "early sync errors", nerr, 2);
    count_chk("R8", "valids incl aborted frame", nvalid, 10);
    // R9: free-running wrap with no sync
    repeat (300) step(1'b0, 1'($urandom));
    count_chk("R9", "errors after wrap", nerr, 2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge sclk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule